// File: doc/BRIEF.md
# Strobe-Handshake Parallel Byte Port (Device Side)

This block sits on the device side of an 8-bit parallel port driven by an external controller. The controller pulls a byte out of the device with an active-low read strobe and pushes a byte in with an active-low write strobe. Two active-low flags tell it when it may strobe: one says a byte is waiting to be read, the other says there is room for a byte to be written. The strobes are not related to the block clock, so both pass through two-flop synchronizers, and every action is taken on edges of the synchronized strobes.

Inside, two small buffers connect the port to the on-chip core. The core fills the outbound buffer through a valid/ready input and drains the inbound buffer through a valid/ready output. Each buffer reports empty and full to the core. The tri-state data bus appears as a separate input, a separate output and an output enable. Each flag works as a strict handshake for one byte. A strobe knocks the flag inactive. After the strobe ends, the flag stays inactive for a parameterized number of clock cycles. It returns to active only if data (or room) is still there.

Top module: `pfifo_strobe_slave`

## Requirements
- R1: During and after reset, with no further stimulus: rd_avail_n=1, wr_room_n=0, bus_oe=0, src_ready=1, src_empty=1, src_full=0, snk_valid=0, snk_empty=1, snk_full=0.
- R2: A read-strobe fall taken while rd_avail_n=0 removes the oldest outbound byte. From the third clock edge after the fall, the block drives that byte on bus_dout with bus_oe=1, and holds it until the synchronized strobe rises. Bytes leave in the order the core supplied them.
- R3: rd_avail_n stays low while an accepted read strobe is low. It goes high by the third clock edge after the strobe rises and stays high for at least DEAD_CYC cycles. After that it goes low only if the outbound buffer still holds a byte.
- R4: A write-strobe fall taken while wr_room_n=0 captures bus_din into the inbound buffer. The core then receives the captured bytes on snk_data in strobe order.
- R5: wr_room_n goes high by the third clock edge after an accepted write strobe falls. It stays high while the strobe is low and for at least DEAD_CYC cycles after the rise. After that it goes low only if the inbound buffer has room.
- R6: A read strobe while rd_avail_n=1 is ignored: bus_oe stays 0 and no byte is removed. A write strobe while wr_room_n=1 is ignored: no byte is stored. This covers strobes that arrive during the dead time.
- R7: The outbound buffer holds DEPTH bytes. src_ready=0 and src_full=1 when it is full. src_empty=1 when it holds nothing.
- R8: The inbound buffer holds DEPTH bytes. snk_full=1 after DEPTH accepted writes. snk_valid=0 and snk_empty=1 when it holds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strb_rd_n | input | 1 | Read strobe from the controller, active low, asynchronous |
| strb_wr_n | input | 1 | Write strobe from the controller, active low, asynchronous |
| bus_din | input | DW | Byte on the bus when the controller drives it |
| bus_dout | output | DW | Byte the block drives during a read |
| bus_oe | output | 1 | Drive enable for bus_dout |
| rd_avail_n | output | 1 | Low when a byte may be read |
| wr_room_n | output | 1 | Low when a byte may be written |
| src_data | input | DW | Byte from the core into the outbound buffer |
| src_valid | input | 1 | src_data is offered |
| src_ready | output | 1 | Outbound buffer accepts the byte |
| src_full | output | 1 | Outbound buffer full |
| src_empty | output | 1 | Outbound buffer empty |
| snk_data | output | DW | Oldest byte of the inbound buffer |
| snk_valid | output | 1 | snk_data holds a byte |
| snk_ready | input | 1 | Core takes snk_data |
| snk_full | output | 1 | Inbound buffer full |
| snk_empty | output | 1 | Inbound buffer empty |

## Verification
The bench builds the block with DEPTH=4 and DEAD_CYC=8, keeping DW=8. The shallow depth makes both buffers fill within a handful of strobes, so the full, wrap-around and refused-strobe cases come up often in the random phase as well as in the directed ones. The short dead time lets the bench probe the flag inside its dead window, strobe into that window, and watch the flag re-arm, all at little cost per byte.

// File: rtl/pfifo_strobe_slave.sv
module pfifo_strobe_slave #(
  parameter int DW       = 8,
  parameter int DEPTH    = 16,
  parameter int DEAD_CYC = 25
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strb_rd_n,
  input  logic          strb_wr_n,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  output logic          rd_avail_n,
  output logic          wr_room_n,
  input  logic [DW-1:0] src_data,
  input  logic          src_valid,
  output logic          src_ready,
  output logic          src_full,
  output logic          src_empty,
  output logic [DW-1:0] snk_data,
  output logic          snk_valid,
  input  logic          snk_ready,
  output logic          snk_full,
  output logic          snk_empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(DEAD_CYC + 1);

  function automatic logic [AW-1:0] ptr_nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // strobe synchronizers plus one history stage
  logic [2:0] rd_sy, wr_sy;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_sy <= 3'b111;
      wr_sy <= 3'b111;
    end else begin
      rd_sy <= {rd_sy[1:0], strb_rd_n};
      wr_sy <= {wr_sy[1:0], strb_wr_n};
    end

  logic rd_fall, rd_rise, wr_fall, wr_rise;
  assign rd_fall = rd_sy[2] & ~rd_sy[1];
  assign rd_rise = ~rd_sy[2] & rd_sy[1];
  assign wr_fall = wr_sy[2] & ~wr_sy[1];
  assign wr_rise = ~wr_sy[2] & wr_sy[1];

  // outbound buffer: core -> controller
  logic [DW-1:0] omem [DEPTH];
  logic [AW-1:0] owp, orp;
  logic [CW-1:0] ocnt;
  logic          src_push, rd_take, rd_busy;
  logic [TW-1:0] rd_dead;

  assign src_ready  = (ocnt != CW'(DEPTH));
  assign src_full   = ~src_ready;
  assign src_empty  = (ocnt == '0);
  assign src_push   = src_valid & src_ready;
  assign rd_take    = rd_fall & ~rd_avail_n & ~rd_busy;
  assign rd_avail_n = (rd_dead != '0) | (~rd_busy & src_empty);
  assign bus_oe     = rd_busy;

  always_ff @(posedge clk)
    if (src_push) omem[owp] <= src_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      owp      <= '0;
      orp      <= '0;
      ocnt     <= '0;
      rd_busy  <= 1'b0;
      rd_dead  <= '0;
      bus_dout <= '0;
    end else begin
      if (src_push) owp <= ptr_nxt(owp);
      if (rd_take) begin
        orp      <= ptr_nxt(orp);
        bus_dout <= omem[orp];
        rd_busy  <= 1'b1;
      end
      ocnt <= ocnt + CW'(src_push) - CW'(rd_take);
      if (rd_busy && rd_rise) begin
        rd_busy <= 1'b0;
        rd_dead <= TW'(DEAD_CYC);
      end else if (rd_dead != '0) begin
        rd_dead <= rd_dead - 1'b1;
      end
    end

  // inbound buffer: controller -> core
  logic [DW-1:0] imem [DEPTH];
  logic [AW-1:0] iwp, irp;
  logic [CW-1:0] icnt;
  logic          snk_pop, wr_take, wr_busy;
  logic [TW-1:0] wr_dead;

  assign snk_full  = (icnt == CW'(DEPTH));
  assign snk_empty = (icnt == '0);
  assign snk_valid = ~snk_empty;
  assign snk_data  = imem[irp];
  assign snk_pop   = snk_valid & snk_ready;
  assign wr_take   = wr_fall & ~wr_room_n;
  assign wr_room_n = wr_busy | (wr_dead != '0) | snk_full;

  always_ff @(posedge clk)
    if (wr_take) imem[iwp] <= bus_din;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      iwp     <= '0;
      irp     <= '0;
      icnt    <= '0;
      wr_busy <= 1'b0;
      wr_dead <= '0;
    end else begin
      if (wr_take) begin
        iwp     <= ptr_nxt(iwp);
        wr_busy <= 1'b1;
      end
      if (snk_pop) irp <= ptr_nxt(irp);
      icnt <= icnt + CW'(wr_take) - CW'(snk_pop);
      if (wr_busy && wr_rise) begin
        wr_busy <= 1'b0;
        wr_dead <= TW'(DEAD_CYC);
      end else if (wr_dead != '0) begin
        wr_dead <= wr_dead - 1'b1;
      end
    end

endmodule

// File: rtl/pfifo_strobe_slave_chk.sv
module pfifo_strobe_slave_chk #(
  parameter int DW       = 8,
  parameter int DEAD_CYC = 25
)(
  input logic          clk,
  input logic          rst_n,
  input logic          bus_oe,
  input logic [DW-1:0] bus_dout,
  input logic          rd_avail_n,
  input logic          wr_room_n,
  input logic          wr_busy,
  input logic          src_full,
  input logic          src_ready,
  input logic          snk_empty,
  input logic          snk_valid
);
  localparam int GW = $clog2(DEAD_CYC + 2);

  logic [GW-1:0] rd_gap, wr_gap;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_gap <= GW'(DEAD_CYC);
      wr_gap <= GW'(DEAD_CYC);
    end else begin
      if (bus_oe) rd_gap <= '0;
      else if (rd_gap < GW'(DEAD_CYC)) rd_gap <= rd_gap + 1'b1;
      if (wr_busy) wr_gap <= '0;
      else if (wr_gap < GW'(DEAD_CYC)) wr_gap <= wr_gap + 1'b1;
    end

  a_r2_dout_held: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe && $past(bus_oe) |-> $stable(bus_dout));
  a_r6_read_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> $past(!rd_avail_n));
  a_r3_read_dead_time: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_avail_n) |-> rd_gap >= GW'(DEAD_CYC));
  a_r4_write_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_busy) |-> $past(!wr_room_n));
  a_r5_write_dead_time: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_room_n) |-> wr_gap >= GW'(DEAD_CYC));
  a_r5_room_high_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> wr_room_n);
  a_r7_full_blocks_core: assert property (@(posedge clk) disable iff (!rst_n)
    src_full |-> !src_ready);
  a_r8_empty_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    snk_empty |-> !snk_valid);
endmodule

bind pfifo_strobe_slave pfifo_strobe_slave_chk #(.DW(DW), .DEAD_CYC(DEAD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_oe(bus_oe), .bus_dout(bus_dout),
  .rd_avail_n(rd_avail_n), .wr_room_n(wr_room_n), .wr_busy(wr_busy),
  .src_full(src_full), .src_ready(src_ready),
  .snk_empty(snk_empty), .snk_valid(snk_valid)
);

// File: tb/pfifo_strobe_slave_test.sv
module pfifo_strobe_slave_test;
  localparam int DW = 8, DEPTH = 4, DEAD = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic strb_rd_n = 1'b1, strb_wr_n = 1'b1;
  logic [DW-1:0] bus_din = '0, src_data = '0;
  logic src_valid = 1'b0, snk_ready = 1'b0;
  logic [DW-1:0] bus_dout, snk_data;
  logic bus_oe, rd_avail_n, wr_room_n, src_ready, src_full, src_empty;
  logic snk_valid, snk_full, snk_empty;

  always #2 clk = ~clk;

  pfifo_strobe_slave #(.DW(DW), .DEPTH(DEPTH), .DEAD_CYC(DEAD)) uut (
    .clk(clk), .rst_n(rst_n), .strb_rd_n(strb_rd_n), .strb_wr_n(strb_wr_n),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .rd_avail_n(rd_avail_n), .wr_room_n(wr_room_n),
    .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
    .src_full(src_full), .src_empty(src_empty),
    .snk_data(snk_data), .snk_valid(snk_valid), .snk_ready(snk_ready),
    .snk_full(snk_full), .snk_empty(snk_empty));

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [DW-1:0] oq[$];
  logic [DW-1:0] iq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_out_flag_n();
    return oq.size() == 0;
  endfunction
  function automatic bit exp_in_flag_n();
    return iq.size() == DEPTH;
  endfunction

  task automatic core_push(input logic [DW-1:0] b);
    @(negedge clk);
    chk(src_ready == 1'b1, "R7 src_ready before push", int'(src_ready), 1);
    src_valid = 1'b1; src_data = b;
    @(negedge clk);
    src_valid = 1'b0;
    oq.push_back(b);
  endtask

  task automatic core_pop();
    @(negedge clk);
    chk(snk_valid == 1'b1, "R8 snk_valid", int'(snk_valid), 1);
    chk(snk_data == iq[0], "R4 snk_data order", int'(snk_data), int'(iq[0]));
    snk_ready = 1'b1;
    @(negedge clk);
    snk_ready = 1'b0;
    void'(iq.pop_front());
  endtask

  // expect_ok: flag was active before the strobe
  task automatic host_read(input bit expect_ok, input bit wait_dead);
    logic [DW-1:0] e;
    e = expect_ok ? oq[0] : '0;
    @(negedge clk);
    strb_rd_n = 1'b0;
    repeat (6) @(negedge clk);
    if (expect_ok) begin
      chk(bus_oe == 1'b1, "R2 oe during read", int'(bus_oe), 1);
      chk(bus_dout == e, "R2 read byte", int'(bus_dout), int'(e));
      chk(rd_avail_n == 1'b0, "R3 flag low while strobe low", int'(rd_avail_n), 0);
      void'(oq.pop_front());
    end else begin
      chk(bus_oe == 1'b0, "R6 ignored read no oe", int'(bus_oe), 0);
    end
    strb_rd_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(bus_oe == 1'b0, "R2 oe off after rise", int'(bus_oe), 0);
    if (expect_ok)
      chk(rd_avail_n == 1'b1, "R3 flag high in dead time", int'(rd_avail_n), 1);
    if (wait_dead) begin
      repeat (DEAD + 2) @(negedge clk);
      chk(rd_avail_n == exp_out_flag_n(), "R3 flag re-arm", int'(rd_avail_n), int'(exp_out_flag_n()));
    end
  endtask

  task automatic host_write(input logic [DW-1:0] b, input bit expect_ok);
    @(negedge clk);
    bus_din = b;
    @(negedge clk);
    strb_wr_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(wr_room_n == 1'b1, "R5 flag high while strobe low", int'(wr_room_n), 1);
    if (expect_ok) iq.push_back(b);
    strb_wr_n = 1'b1;
    repeat (2) @(negedge clk);
    bus_din = ~b;
    @(negedge clk);
    chk(wr_room_n == 1'b1, "R5 flag high in dead time", int'(wr_room_n), 1);
    repeat (DEAD + 2) @(negedge clk);
    chk(wr_room_n == exp_in_flag_n(), "R5 flag re-arm", int'(wr_room_n), int'(exp_in_flag_n()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rd_avail_n == 1'b1, "R1 rd_avail_n", int'(rd_avail_n), 1);
    chk(wr_room_n == 1'b0, "R1 wr_room_n", int'(wr_room_n), 0);
    chk(bus_oe == 1'b0, "R1 bus_oe", int'(bus_oe), 0);
    chk({src_ready, src_full, src_empty} == 3'b101, "R1 src flags", int'({src_ready, src_full, src_empty}), 5);
    chk({snk_valid, snk_full, snk_empty} == 3'b001, "R1 snk flags", int'({snk_valid, snk_full, snk_empty}), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(rd_avail_n == 1'b1 && wr_room_n == 1'b0, "R1 after release", int'({rd_avail_n, wr_room_n}), 2);

    // R6 read strobe on empty buffer
    host_read(1'b0, 1'b1);
    // R7 fill outbound buffer
    for (int i = 0; i < DEPTH; i++) core_push(8'hA0 + 8'(i));
    @(negedge clk);
    chk(src_full == 1'b1 && src_ready == 1'b0, "R7 full blocks core", int'({src_full, src_ready}), 2);
    chk(rd_avail_n == 1'b0, "R3 flag low with data", int'(rd_avail_n), 0);
    // R2 read one, then strobe inside dead time (R6)
    host_read(1'b1, 1'b0);
    host_read(1'b0, 1'b0);
    repeat (DEAD + 2) @(negedge clk);
    chk(rd_avail_n == 1'b0, "R3 re-arm data left", int'(rd_avail_n), 0);
    // drain remaining in order (R2), last leaves flag high (R3)
    while (oq.size() > 0) host_read(1'b1, 1'b1);
    chk(src_empty == 1'b1, "R7 src_empty after drain", int'(src_empty), 1);
    // R6 pointer unchanged: next byte appears after ignored strobes
    core_push(8'h5A);
    host_read(1'b1, 1'b1);

    // R4/R5/R8 fill inbound buffer
    for (int i = 0; i < DEPTH; i++) host_write(8'h30 + 8'(i), 1'b1);
    chk(snk_full == 1'b1, "R8 snk_full", int'(snk_full), 1);
    host_write(8'hEE, 1'b0);  // R6 ignored write while full
    while (iq.size() > 0) core_pop();
    @(negedge clk);
    chk(snk_empty == 1'b1 && snk_valid == 1'b0, "R8 empty after drain R6 no extra", int'({snk_empty, snk_valid}), 2);
    chk(wr_room_n == 1'b0, "R5 room after drain", int'(wr_room_n), 0);

    // random phase
    for (int it = 0; it < 200; it++) begin
      int op;
      op = int'($urandom % 4);
      case (op)
        0: if (oq.size() < DEPTH) core_push(8'($urandom));
        1: host_read(oq.size() > 0, 1'b1);
        2: host_write(8'($urandom), iq.size() < DEPTH);
        default: if (iq.size() > 0) core_pop();
      endcase
    end
    @(negedge clk);
    chk(src_empty == (oq.size() == 0), "R7 final src_empty", int'(src_empty), int'(oq.size() == 0));
    chk(snk_empty == (iq.size() == 0), "R8 final snk_empty", int'(snk_empty), int'(iq.size() == 0));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule